// File: doc/BRIEF.md
# Level-Interrupt EOI Handler with Storm Throttling

This block sits next to a table of interrupt redirection entries and handles end-of-interrupt (EOI) broadcasts. Each broadcast carries a vector and a flag that says whether it closes a level-triggered interrupt. The handler compares the vector with every entry, one entry per cycle in ascending pin order. It signals an acknowledge for each entry that matches. For level EOIs, unless directed-EOI mode is on, it pulses a clear of that entry's remote-IRR bit. If the pin is still pending and unmasked, it asks for the interrupt to be delivered again.

A level interrupt whose source never drops would keep the processor busy with immediate re-deliveries. To prevent this, a counter per pin counts consecutive immediate re-deliveries. When a pin reaches the storm limit, the handler does not deliver again at once. It clears that pin's counter and arms a deferral timer. When the timer expires, every level-triggered entry that is pending and has remote IRR clear gets one delivery request. The entry table, the remote-IRR storage and the delivery path all live outside this block. It sees them through flat input vectors and drives one-hot request vectors back to them.

Top module: `eoi_storm_throttle`

## Requirements
- R1: While a scan runs, `ack_valid` is high with `ack_pin` = k in the scan cycle for pin k exactly when entry k's vector equals the latched EOI vector, for level and edge entries alike; acknowledges come in ascending pin order.
- R2: For an EOI with `eoi_level`=0, or one accepted while `directed_eoi`=1, no bit of `rirr_clr` is raised, no scan-driven delivery is requested, and no storm counter changes.
- R3: For a level EOI without directed mode, each matching pin k gets a one-cycle `rirr_clr[k]` pulse in its scan cycle.
- R4: When pin k is cleared and is unmasked (`ent_mask[k]`=0) and pending (`pin_pending[k]`=1), and its counter is below STORM_LIMIT-1, `deliver_req[k]` pulses in the same cycle and the counter increments.
- R5: When the counter of such a pin already equals STORM_LIMIT-1, no immediate request is made; the counter returns to zero and the deferral timer is loaded, so `defer_armed` is high from the next cycle.
- R6: A cleared pin that is masked or not pending gets no request, and its counter returns to zero.
- R7: The timer expires in the DEFER_CYCLES-th cycle after the one in which it was loaded. In that cycle `deliver_req` includes every pin with `ent_level`=1, `pin_pending`=1 and `ent_rirr`=0, and `defer_armed` falls in the next cycle.
- R8: Loading the timer while it is already armed restarts the full DEFER_CYCLES count.
- R9: An EOI presented while `busy` is low starts a scan: `busy` is high for exactly NPINS cycles, starting in the next cycle. An `eoi_valid` presented while `busy` is high is ignored.
- R10: Reset clears all counters, disarms the timer and ends any scan; all outputs are then low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| eoi_valid | input | 1 | EOI broadcast present |
| eoi_vector | input | VEC_W | Vector being retired |
| eoi_level | input | 1 | 1 = level-triggered EOI |
| directed_eoi | input | 1 | 1 = remote IRR is left alone on broadcast |
| ent_vector | input | NPINS*VEC_W | Vector of each entry, pin k at bits k*VEC_W upward |
| ent_level | input | NPINS | Entry trigger mode, 1 = level |
| ent_mask | input | NPINS | Entry mask bit |
| ent_rirr | input | NPINS | Entry remote-IRR bit |
| pin_pending | input | NPINS | Pin request latched and not yet dropped |
| busy | output | 1 | Scan in progress |
| ack_valid | output | 1 | Acknowledge notification this cycle |
| ack_pin | output | $clog2(NPINS) | Pin being acknowledged |
| rirr_clr | output | NPINS | One-hot remote-IRR clear pulse |
| deliver_req | output | NPINS | Delivery request per pin |
| defer_armed | output | 1 | Deferral timer running |

## Verification
The bench uses a table of four pins. Two level pins share a vector, one edge pin has its own vector, and one masked level pin has a third vector. Edge, directed and unmatched EOIs show that only acknowledges come out and the counters stay untouched. Repeated level EOIs with one pin pending and one idle separate the immediate path from the counter reset. Continuing past the limit shows the trip to deferral, and the expiry is checked against mixed remote-IRR inputs. A second storm that trips while the timer is armed checks the restart. A back-to-back EOI and a reset while the timer is armed cover the dropped request and the cancellation.

// File: rtl/eoi_storm_throttle.sv
module eoi_storm_throttle #(
  parameter int NPINS        = 24,
  parameter int VEC_W        = 8,
  parameter int STORM_LIMIT  = 10000,
  parameter int DEFER_CYCLES = 100000
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   eoi_valid,
  input  logic [VEC_W-1:0]       eoi_vector,
  input  logic                   eoi_level,
  input  logic                   directed_eoi,
  input  logic [NPINS*VEC_W-1:0] ent_vector,
  input  logic [NPINS-1:0]       ent_level,
  input  logic [NPINS-1:0]       ent_mask,
  input  logic [NPINS-1:0]       ent_rirr,
  input  logic [NPINS-1:0]       pin_pending,
  output logic                   busy,
  output logic                   ack_valid,
  output logic [$clog2(NPINS)-1:0] ack_pin,
  output logic [NPINS-1:0]       rirr_clr,
  output logic [NPINS-1:0]       deliver_req,
  output logic                   defer_armed
);
  localparam int IW = $clog2(NPINS);
  localparam int CW = $clog2(STORM_LIMIT);
  localparam int TW = $clog2(DEFER_CYCLES + 1);

  logic             busy_q, lvl_q, dir_q, armed_q;
  logic [IW-1:0]    idx_q;
  logic [VEC_W-1:0] vec_q;
  logic [TW-1:0]    tmr_q;
  logic [CW-1:0]    cnt_q [NPINS];

  wire [VEC_W-1:0] cur_vec = ent_vector[idx_q*VEC_W +: VEC_W];
  wire             hit     = busy_q && (cur_vec == vec_q);
  wire             do_clr  = hit && lvl_q && !dir_q;
  wire             live    = do_clr && !ent_mask[idx_q] && pin_pending[idx_q];
  wire             trip    = live && (cnt_q[idx_q] == CW'(STORM_LIMIT - 1));
  wire             expire  = armed_q && (tmr_q == '0);
  wire [NPINS-1:0] sel     = NPINS'(1) << idx_q;

  assign busy        = busy_q;
  assign ack_valid   = hit;
  assign ack_pin     = idx_q;
  assign rirr_clr    = do_clr ? sel : '0;
  assign deliver_req = ((live && !trip) ? sel : '0)
                     | (expire ? (ent_level & pin_pending & ~ent_rirr) : '0);
  assign defer_armed = armed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
      vec_q  <= '0;
      lvl_q  <= 1'b0;
      dir_q  <= 1'b0;
    end else if (busy_q) begin
      if (idx_q == IW'(NPINS - 1)) busy_q <= 1'b0;
      else                         idx_q  <= idx_q + 1'b1;
    end else if (eoi_valid) begin
      busy_q <= 1'b1;
      idx_q  <= '0;
      vec_q  <= eoi_vector;
      lvl_q  <= eoi_level;
      dir_q  <= directed_eoi;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      tmr_q   <= '0;
    end else if (trip) begin
      armed_q <= 1'b1;
      tmr_q   <= TW'(DEFER_CYCLES - 1);
    end else if (expire) begin
      armed_q <= 1'b0;
    end else if (armed_q) begin
      tmr_q   <= tmr_q - 1'b1;
    end
  end

  for (genvar g = 0; g < NPINS; g++) begin : g_cnt
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        cnt_q[g] <= '0;
      else if (do_clr && idx_q == IW'(g))
        cnt_q[g] <= (!live || trip) ? '0 : cnt_q[g] + 1'b1;
    end
  end
endmodule

// File: rtl/eoi_storm_throttle_chk.sv
module eoi_storm_throttle_chk #(
  parameter int NPINS = 24,
  parameter int IW    = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic             ack_valid,
  input logic [IW-1:0]    ack_pin,
  input logic [NPINS-1:0] rirr_clr
);
  logic [31:0] run;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) run <= '0;
    else        run <= busy ? run + 1 : '0;

  AST_ACK_IN_SCAN: assert property (@(posedge clk) disable iff (!rst_n)
    ack_valid |-> busy); // R1
  AST_ACK_ASCENDING: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_valid && busy && $past(ack_valid) && $past(busy)) |-> ack_pin > $past(ack_pin)); // R1
  AST_CLR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (|rirr_clr) |-> (ack_valid && $onehot0(rirr_clr))); // R3
  AST_SCAN_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> run < NPINS); // R9
endmodule

bind eoi_storm_throttle eoi_storm_throttle_chk #(.NPINS(NPINS), .IW(IW)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .ack_valid(ack_valid),
  .ack_pin(ack_pin), .rirr_clr(rirr_clr)
);

// File: tb/test_eoi_storm_throttle.sv
module test_eoi_storm_throttle;
  localparam int N = 4, VW = 8, LIM = 3, DEF = 40, IW = 2;

  logic clk = 0, rst_n = 0;
  logic eoi_valid = 0, eoi_level = 0, directed_eoi = 0;
  logic [VW-1:0] eoi_vector = '0;
  logic [N*VW-1:0] ent_vector;
  logic [N-1:0] ent_level, ent_mask, ent_rirr = '0, pin_pending = '0;
  logic busy, ack_valid, defer_armed;
  logic [IW-1:0] ack_pin;
  logic [N-1:0] rirr_clr, deliver_req;

  always #10 clk = ~clk;

  eoi_storm_throttle #(.NPINS(N), .VEC_W(VW), .STORM_LIMIT(LIM), .DEFER_CYCLES(DEF)) i_eoi_storm_throttle (
    .clk(clk), .rst_n(rst_n), .eoi_valid(eoi_valid), .eoi_vector(eoi_vector),
    .eoi_level(eoi_level), .directed_eoi(directed_eoi), .ent_vector(ent_vector),
    .ent_level(ent_level), .ent_mask(ent_mask), .ent_rirr(ent_rirr),
    .pin_pending(pin_pending), .busy(busy), .ack_valid(ack_valid), .ack_pin(ack_pin),
    .rirr_clr(rirr_clr), .deliver_req(deliver_req), .defer_armed(defer_armed));

  int errors = 0, checks = 0;
  bit done = 0;

  // reference model
  bit m_busy, m_lvl, m_dir, m_armed;
  int m_idx, m_tmr;
  int m_cnt [N];
  logic [VW-1:0] m_vec;

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_armed = 0; m_idx = 0; m_tmr = 0;
      foreach (m_cnt[i]) m_cnt[i] = 0;
      chk("R10", "busy", busy, 0);
      chk("R10", "armed", defer_armed, 0);
      chk("R10", "deliver", deliver_req, 0);
      chk("R10", "ack", ack_valid, 0);
    end else begin
      bit match, clr, live, trip, expire;
      logic [N-1:0] e_clr, e_del;
      match  = m_busy && (ent_vector[m_idx*VW +: VW] == m_vec);
      clr    = match && m_lvl && !m_dir;
      live   = clr && !ent_mask[m_idx] && pin_pending[m_idx];
      trip   = live && (m_cnt[m_idx] == LIM - 1);
      expire = m_armed && (m_tmr == 0);
      e_clr  = clr ? N'(1) << m_idx : '0;
      e_del  = (live && !trip) ? N'(1) << m_idx : '0;
      if (expire) e_del |= ent_level & pin_pending & ~ent_rirr;
      chk("R9", "busy", busy, m_busy);
      chk("R1", "ack_valid", ack_valid, match);
      if (match) chk("R1", "ack_pin", ack_pin, m_idx);
      chk("R2/R3", "rirr_clr", rirr_clr, e_clr);
      chk("R4/R5/R6/R7", "deliver_req", deliver_req, e_del);
      chk("R5/R7/R8", "defer_armed", defer_armed, m_armed);
      if (clr) m_cnt[m_idx] = (!live || trip) ? 0 : m_cnt[m_idx] + 1;
      if (trip) begin m_armed = 1; m_tmr = DEF - 1; end
      else if (expire) m_armed = 0;
      else if (m_armed) m_tmr--;
      if (m_busy) begin
        if (m_idx == N - 1) m_busy = 0; else m_idx++;
      end else if (eoi_valid) begin
        m_busy = 1; m_idx = 0; m_vec = eoi_vector; m_lvl = eoi_level; m_dir = directed_eoi;
      end
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic eoi(input logic [VW-1:0] v, input logic lv, input logic dr);
    eoi_vector = v; eoi_level = lv; directed_eoi = dr; eoi_valid = 1;
    cyc(1);
    eoi_valid = 0;
    cyc(N + 1);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #2000000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    // pin0 level 0x30, pin1 edge 0x31, pin2 level 0x30, pin3 level masked 0x40
    ent_vector = {8'h40, 8'h30, 8'h31, 8'h30};
    ent_level  = 4'b1101;
    ent_mask   = 4'b1000;
    cyc(3);                       // R10 reset state checked by model
    rst_n = 1;
    cyc(2);
    eoi(8'h30, 0, 0);             // R2 edge EOI: acks only
    eoi(8'h31, 1, 1);             // R2 directed: ack only
    eoi(8'h55, 1, 0);             // R1 no match, no ack
    pin_pending = 4'b1001;
    eoi(8'h30, 1, 0);             // R3 R4 pin0 redelivered, R6 pin2 idle
    eoi(8'h40, 1, 0);             // R6 masked pin3
    eoi(8'h30, 1, 0);             // R4 second
    eoi(8'h30, 1, 0);             // R5 trips
    chk("R5", "armed after trip", defer_armed, 1);
    pin_pending = 4'b0101;
    ent_rirr    = 4'b0100;
    cyc(DEF);                     // R7 expiry, pin0 only (pin2 rirr set)
    chk("R7", "armed after expiry", defer_armed, 0);
    pin_pending = 4'b0001;
    ent_rirr    = 4'b0000;
    // R9 back-to-back valid: second ignored
    eoi_vector = 8'h30; eoi_level = 1; directed_eoi = 0; eoi_valid = 1;
    cyc(2);
    eoi_valid = 0;
    cyc(N + 1);
    eoi(8'h30, 1, 0);
    eoi(8'h30, 1, 0);             // trips, armed
    eoi(8'h30, 1, 0);
    eoi(8'h30, 1, 0);
    eoi(8'h30, 1, 0);             // R8 re-trip restarts timer
    cyc(DEF + 4);
    eoi(8'h30, 1, 0);
    eoi(8'h30, 1, 0);
    eoi(8'h30, 1, 0);             // armed again
    rst_n = 0;                    // R10 cancels timer
    cyc(2);
    chk("R10", "armed in reset", defer_armed, 0);
    rst_n = 1;
    cyc(DEF + 4);
    chk("R10", "no expiry after reset", defer_armed, 0);
    finish_run();
  end
endmodule